// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Router

This block takes an inter-processor interrupt command and works out which of `NUM_UNITS` local interrupt units should accept it. Each unit supplies an 8-bit physical ID, an 8-bit logical ID and a 4-bit addressing format code, together with an enable bit. The command carries an 8-bit destination, a physical/logical mode bit, a 2-bit shorthand, a 3-bit delivery mode and the index of the sending unit. From these the block builds a per-unit match set.

For most delivery modes the match set is the result. For lowest-priority delivery the set is cut down to one unit by a rotating search. The search starts just after the unit picked last time and takes the first matched unit that is enabled. When no matched unit is enabled, the lowest-numbered matched unit is used. When nothing matches at all, unit 0 is used.

Commands enter on a valid/ready handshake. Results leave on a second valid/ready handshake through a single output register. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the command side directly. The unit configuration and enable inputs are sampled on the edge that accepts the command.

Top module: `ipi_dest_router`

## Requirements
- R1: With shorthand 2'b00 and `cmd_logical`=0 (physical), unit u matches when `cmd_dest` equals its physical ID or `cmd_dest` is 8'hFF.
- R2: With shorthand 2'b00, `cmd_logical`=1 and unit format 4'hF (flat), unit u matches when the bitwise AND of its logical ID and `cmd_dest` is nonzero.
- R3: With shorthand 2'b00, `cmd_logical`=1 and unit format 4'h0 (cluster), unit u matches when logical ID bits 7:4 equal `cmd_dest` bits 7:4 and logical ID bits 3:0 ANDed with `cmd_dest` bits 3:0 is nonzero.
- R4: In logical mode, a unit whose format code is neither 4'hF nor 4'h0 never matches.
- R5: Shorthand 2'b01 matches only unit `cmd_src`, 2'b10 matches every unit, and 2'b11 matches every unit except `cmd_src`. With any of these shorthands, the destination and mode are ignored.
- R6: For delivery mode 3'b001 (lowest priority), units are searched from pointer+1 upward, wrapping modulo `NUM_UNITS`. The first unit that is both matched and enabled is the sole bit of `out_mask`, and the pointer moves to it.
- R7: For lowest-priority delivery with no matched unit enabled, `out_mask` holds only the lowest-numbered matched unit. If no unit matched, it holds unit 0. In both cases the pointer is unchanged.
- R8: After reset, `out_valid` is 0, `cmd_ready` is 1 and the pointer is `NUM_UNITS`-1, so the first lowest-priority search tries unit 0 first.
- R9: A command accepted on an edge appears on `out_valid`/`out_mask` after that edge. While `out_valid` is high and `out_ready` is low, the output holds steady and `cmd_ready` is 0.
- R10: For any delivery mode other than 3'b001, `out_mask` is the full match set, and unit enable bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_dest | input | 8 | Destination field |
| cmd_logical | input | 1 | 0 physical, 1 logical destination |
| cmd_shorthand | input | 2 | 00 none, 01 self, 10 all, 11 all but self |
| cmd_dlv | input | 3 | Delivery mode; 3'b001 is lowest priority |
| cmd_src | input | IDX_W | Index of the sending unit |
| unit_id | input | NUM_UNITS*8 | Physical IDs, unit u at bits u*8+:8 |
| unit_ldr | input | NUM_UNITS*8 | Logical IDs, unit u at bits u*8+:8 |
| unit_fmt | input | NUM_UNITS*4 | Format codes, unit u at bits u*4+:4 |
| unit_en | input | NUM_UNITS | Unit enable bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | NUM_UNITS | Accepting units, bit u for unit u |

## Verification
The bench aims at the wrap of the rotating search past the top unit and at the cases where the pointer must stay put. A design that moved the pointer on a fallback pick, or that started the search at the pointer itself instead of after it, would send repeated commands to the wrong unit. Physical IDs are drawn from a small pool so that several units share an ID and broadcast 8'hFF collides with real IDs. Cluster and flat units are mixed so that a matcher comparing the wrong nibble, or one that treats an unknown format as flat, sets extra bits in the mask. Random stalls on `out_ready` expose an output register that changes or drops its result while it is held.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_SELF  = 2'b01,
    SH_ALL   = 2'b10,
    SH_OTHER = 2'b11
  } shorthand_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [2:0] DLV_LOWEST  = 3'b001;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

  typedef struct packed {
    logic [7:0] dest;
    logic       logical;
    shorthand_e sh;
  } route_cmd_t;
endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
  import ipi_router_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int UNIT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  route_cmd_t       cmd,
  input  logic [IDX_W-1:0] src,
  input  logic [7:0]       phys_id,
  input  logic [7:0]       log_id,
  input  logic [3:0]       fmt,
  output logic             hit
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(UNIT_IDX);

  logic is_self;
  logic phys_hit;
  logic flat_hit;
  logic clus_hit;
  logic log_hit;

  assign is_self  = (src == MY_IDX);
  assign phys_hit = (cmd.dest == DEST_BCAST) || (cmd.dest == phys_id);
  assign flat_hit = |(log_id & cmd.dest);
  assign clus_hit = (log_id[7:4] == cmd.dest[7:4]) && (|(log_id[3:0] & cmd.dest[3:0]));

  always_comb begin
    unique case (fmt)
      FMT_FLAT:    log_hit = flat_hit;
      FMT_CLUSTER: log_hit = clus_hit;
      default:     log_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cmd.sh)
      SH_NONE:  hit = cmd.logical ? log_hit : phys_hit;
      SH_SELF:  hit = is_self;
      SH_ALL:   hit = 1'b1;
      SH_OTHER: hit = !is_self;
      default:  hit = 1'b0;
    endcase
  end

  // R4: unknown format never matches in logical addressing
  a_r4_bad_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.sh == SH_NONE && cmd.logical && fmt != FMT_FLAT && fmt != FMT_CLUSTER) |-> !hit);
  // R5: self shorthand only hits the sender
  a_r5_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.sh == SH_SELF) |-> (hit == (src == MY_IDX)));
  // R1: broadcast destination hits every unit in physical mode
  a_r1_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.sh == SH_NONE && !cmd.logical && cmd.dest == 8'hFF) |-> hit);
endmodule

// File: rtl/ipi_rr_select.sv
module ipi_rr_select #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] matched,
  input  logic [NUM_UNITS-1:0] en,
  input  logic                 advance,
  output logic [NUM_UNITS-1:0] pick
);
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(NUM_UNITS - 1);

  logic [IDX_W-1:0]     ptr_q;
  logic [NUM_UNITS-1:0] cand;
  logic                 found;
  logic [IDX_W-1:0]     rot_idx;
  logic [IDX_W-1:0]     low_idx;

  assign cand = matched & en;

  // rotating search: first candidate strictly after the pointer
  always_comb begin
    found   = 1'b0;
    rot_idx = '0;
    for (int k = 1; k <= NUM_UNITS; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_UNITS;
      if (!found && cand[idx]) begin
        found   = 1'b1;
        rot_idx = IDX_W'(idx);
      end
    end
  end

  // fallback: lowest-numbered matched unit
  always_comb begin
    low_idx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (matched[i]) low_idx = IDX_W'(i);
    end
  end

  always_comb begin
    pick = '0;
    if (found)        pick[rot_idx] = 1'b1;
    else if (|matched) pick[low_idx] = 1'b1;
    else              pick[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr_q <= PTR_RST;
    else if (advance && found) ptr_q <= rot_idx;
  end

  // R6: an enabled matched unit exists -> the pick is one of them
  a_r6_pick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> (|(pick & cand)));
  // R7: pick always stays within the match set when it is not empty
  a_r7_pick_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|matched) |-> ((pick & ~matched) == '0));
  // R7: no candidate -> pointer unchanged
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !(|cand)) |=> $stable(ptr_q));
  a_r6_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pick));
endmodule

// File: rtl/ipi_dest_router.sv
module ipi_dest_router
  import ipi_router_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [7:0]             cmd_dest,
  input  logic                   cmd_logical,
  input  logic [1:0]             cmd_shorthand,
  input  logic [2:0]             cmd_dlv,
  input  logic [IDX_W-1:0]       cmd_src,
  input  logic [NUM_UNITS*8-1:0] unit_id,
  input  logic [NUM_UNITS*8-1:0] unit_ldr,
  input  logic [NUM_UNITS*4-1:0] unit_fmt,
  input  logic [NUM_UNITS-1:0]   unit_en,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NUM_UNITS-1:0]   out_mask
);
  route_cmd_t           cmd;
  logic [NUM_UNITS-1:0] matched;
  logic [NUM_UNITS-1:0] rr_pick;
  logic                 is_lowest;
  logic                 take;
  logic                 valid_q;
  logic                 low_q;
  logic [NUM_UNITS-1:0] mask_q;

  assign cmd.dest    = cmd_dest;
  assign cmd.logical = cmd_logical;
  assign cmd.sh      = shorthand_e'(cmd_shorthand);
  assign is_lowest   = (cmd_dlv == DLV_LOWEST);

  assign cmd_ready = !valid_q || out_ready;
  assign take      = cmd_valid && cmd_ready;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    ipi_unit_match #(.IDX_W(IDX_W), .UNIT_IDX(u)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .src     (cmd_src),
      .phys_id (unit_id[u*8 +: 8]),
      .log_id  (unit_ldr[u*8 +: 8]),
      .fmt     (unit_fmt[u*4 +: 4]),
      .hit     (matched[u])
    );
  end

  ipi_rr_select #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .matched (matched),
    .en      (unit_en),
    .advance (take && is_lowest),
    .pick    (rr_pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      low_q   <= 1'b0;
      mask_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      low_q   <= is_lowest;
      mask_q  <= is_lowest ? rr_pick : matched;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_mask  = mask_q;

  // R9: held result stays put under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)));
  // R9: accepted command is visible on the next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> out_valid);
  // R9: no acceptance while a held result blocks the register
  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !cmd_ready);
  // R6: lowest-priority results carry exactly one unit
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && low_q) |-> $onehot(out_mask));
endmodule

// File: tb/ipi_dest_router_tb.sv
`timescale 1ns/1ps
module ipi_dest_router_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0;
  logic           cmd_ready;
  logic [7:0]     cmd_dest = '0;
  logic           cmd_logical = 1'b0;
  logic [1:0]     cmd_shorthand = '0;
  logic [2:0]     cmd_dlv = '0;
  logic [IW-1:0]  cmd_src = '0;
  logic [N*8-1:0] unit_id = '0;
  logic [N*8-1:0] unit_ldr = '0;
  logic [N*4-1:0] unit_fmt = '0;
  logic [N-1:0]   unit_en = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [N-1:0]   out_mask;

  always #2.5 clk = ~clk;

  ipi_dest_router #(.NUM_UNITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dest(cmd_dest), .cmd_logical(cmd_logical), .cmd_shorthand(cmd_shorthand),
    .cmd_dlv(cmd_dlv), .cmd_src(cmd_src), .unit_id(unit_id), .unit_ldr(unit_ldr),
    .unit_fmt(unit_fmt), .unit_en(unit_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_mask(out_mask)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  bit           m_valid = 0;
  logic [N-1:0] m_mask = '0;
  int           m_ptr = N - 1;
  string        m_tag = "R9";

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit unit_hit(int u);
    logic [7:0] id, ld, d;
    logic [3:0] f;
    id = unit_id[u*8 +: 8]; ld = unit_ldr[u*8 +: 8]; f = unit_fmt[u*4 +: 4]; d = cmd_dest;
    case (cmd_shorthand)
      2'b01: return (u == int'(cmd_src));
      2'b10: return 1'b1;
      2'b11: return (u != int'(cmd_src));
      default: begin
        if (!cmd_logical) return (d == 8'hFF) || (d == id);
        if (f == 4'hF) return (ld & d) != 0;
        if (f == 4'h0) return (ld[7:4] == d[7:4]) && ((ld[3:0] & d[3:0]) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  // advance the model by one edge using the inputs now applied
  task automatic model_step();
    bit take;
    take = cmd_valid && (!m_valid || out_ready);
    if (take) begin
      logic [N-1:0] hits;
      bit any_bad, any_clus;
      any_bad = 0; any_clus = 0;
      for (int u = 0; u < N; u++) begin
        hits[u] = unit_hit(u);
        if (unit_fmt[u*4 +: 4] != 4'hF && unit_fmt[u*4 +: 4] != 4'h0) any_bad = 1;
        if (unit_fmt[u*4 +: 4] == 4'h0) any_clus = 1;
      end
      if (cmd_dlv == 3'b001) begin
        int found;
        found = -1;
        for (int k = 1; k <= N; k++) begin
          int i;
          i = (m_ptr + k) % N;
          if (found < 0 && hits[i] && unit_en[i]) found = i;
        end
        m_mask = '0;
        if (found >= 0) begin
          m_mask[found] = 1'b1; m_ptr = found; m_tag = "R6";
        end else begin
          m_tag = "R7";
          if (hits == '0) m_mask[0] = 1'b1;
          else begin
            int lo;
            lo = -1;
            for (int i = 0; i < N; i++) if (lo < 0 && hits[i]) lo = i;
            m_mask[lo] = 1'b1;
          end
        end
      end else begin
        m_mask = hits;
        if (cmd_shorthand != 2'b00) m_tag = "R5";
        else if ((hits & ~unit_en) != '0) m_tag = "R10";
        else if (!cmd_logical) m_tag = "R1";
        else if (any_bad) m_tag = "R4";
        else if (any_clus) m_tag = "R3";
        else m_tag = "R2";
      end
      m_valid = 1;
    end else if (m_valid && out_ready) begin
      m_valid = 0;
    end
  endtask

  task automatic randomize_inputs(int cyc);
    bit same_fmt;
    logic [3:0] f0;
    cmd_valid = ($urandom_range(0, 9) < 7);
    out_ready = ($urandom_range(0, 9) < 7);
    same_fmt = ($urandom_range(0, 2) == 0);
    f0 = ($urandom_range(0, 1) == 0) ? 4'hF : 4'h0;
    for (int u = 0; u < N; u++) begin
      int r;
      unit_id[u*8 +: 8]  = 8'($urandom_range(0, 11));
      unit_ldr[u*8 +: 8] = 8'($urandom);
      r = $urandom_range(0, 9);
      unit_fmt[u*4 +: 4] = same_fmt ? f0 : (r < 4 ? 4'hF : (r < 8 ? 4'h0 : 4'h5));
    end
    unit_en = ($urandom_range(0, 4) == 0) ? '0 : N'($urandom);
    case ($urandom_range(0, 3))
      0: cmd_dest = 8'hFF;
      1: cmd_dest = unit_id[$urandom_range(0, N-1)*8 +: 8];
      default: cmd_dest = 8'($urandom);
    endcase
    cmd_logical   = $urandom_range(0, 1);
    cmd_shorthand = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
    cmd_dlv       = ($urandom_range(0, 1) == 0) ? 3'b001 : 3'($urandom);
    cmd_src       = IW'($urandom);
    if (cyc % 50 < 6) begin
      // bursts of lowest-priority broadcast commands to walk the pointer
      cmd_valid = 1; out_ready = 1; cmd_shorthand = 2'b10; cmd_dlv = 3'b001;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", 32'(out_valid), 32'd0);
    check("R8", 32'(cmd_ready), 32'd1);
    rst_n = 1'b1;
    // R8: first lowest-priority search starts at unit 0
    cmd_valid = 1; out_ready = 1; cmd_shorthand = 2'b10; cmd_dlv = 3'b001;
    unit_en = '1; unit_fmt = '1;
    model_step();
    @(negedge clk);
    check("R8", 32'(out_mask), 32'h1);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      randomize_inputs(cyc);
      model_step();
      @(negedge clk);
      check("R9", 32'(out_valid), 32'(m_valid));
      check("R9", 32'(cmd_ready), 32'(!m_valid || out_ready));
      if (m_valid) check(m_tag, 32'(out_mask), 32'(m_mask));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule